// File: doc/BRIEF.md
# Multicycle Fetch-Execute Sequencer

This block is the control heart of a small non-pipelined processor in which each instruction is one 32-bit word. Code and data sit in a single word-addressed memory whose latency is not fixed, so the sequencer raises a one-cycle request and then parks until the memory answers with a done pulse. That holds for instruction fetches and for loads and stores alike. The sequencer owns the program counter and the instruction register. It splits the fetched word into register numbers and an operation code, and it steers an external register file, an external ALU and the shared memory. Those units sit outside the block and are reached only through their request, done and data ports.

Operations that need several cycles, such as multiply, are started with a pulse and waited on through a done input. Halt is written as a jump to the highest address. When it executes, the processor stops and reports that it is halted. A free-running cycle counter measures execution time. With the run input low, a step pulse executes exactly one instruction, so software can be traced one instruction at a time.

Top module: `fxCtrlTop`

## Requirements
- R1: While reset is held and in the first cycle after it, `pcOut` is 0, `halted` is 0 and `memReq`, `rfWe` and `aluStart` are 0.
- R2: An instruction fetch is a one-cycle `memReq` with `memWe` low and `memAddr` equal to the PC. The word on `memRdata` in the cycle `memDone` is high is loaded into the instruction register, which is visible on `irOut`.
- R3: After any `memReq`, the sequencer issues no new request, keeps `memAddr` stable and makes no progress until `memDone` arrives, whatever the latency.
- R4: Bits [31:30] of the instruction pick the format: 00 ALU, 01 memory, 10 branch, 11 jump.
- R5: ALU format: rd=[29:25], rs1=[24:20], rs2=[19:15], function=[5:0], which is driven on `aluOp`. A single pulse of `aluStart` starts the operation. If function bit 5 is 0, `aluResult` is taken in the cycle after the pulse. If it is 1, the sequencer waits for `aluDone` and takes `aluResult` then. The result is written to rd.
- R6: Memory format: bit 29 is 1 for a store, data register=[28:24], base register=[23:19], signed word offset=[15:0]. The address is base[19:0] plus the sign-extended offset, modulo 2^20. A load writes the returned word to the data register.
- R7: A store raises `memReq` with `memWe` high, the computed address, and the data register's value on `memWdata`. It writes no register.
- R8: ALU, load and store instructions advance the PC by one word.
- R9: Branch format: bit 29 selects the condition (0: equal, 1: not equal), rs1=[28:24], rs2=[23:19], signed offset=[15:0]. If taken, the new PC is the branch's PC plus the offset. Otherwise it is the branch's PC plus 1.
- R10: Jump format loads the PC with the absolute 20-bit target in bits [19:0].
- R11: A jump to target 0xFFFFF is a halt. `halted` rises, the PC becomes the halt's address plus 1, and no request is issued until a step pulse or reset.
- R12: `cycleCount` increments on every clock while not halted and holds while halted. `cycClr` sets it to 0 on the next edge and takes priority.
- R13: With `runEn` low, a `stepReq` pulse in the idle or halted state executes exactly one instruction, then returns to idle with no further request. With `runEn` high, instructions follow one another without pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run continuously when high |
| stepReq | input | 1 | Execute one instruction from idle or halt |
| cycClr | input | 1 | Clear the cycle counter |
| memReq | output | 1 | One-cycle memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 20 | Word address |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Read data, valid with memDone |
| memDone | input | 1 | Memory access complete |
| rfRdA | output | 5 | Register file read address A |
| rfRdB | output | 5 | Register file read address B |
| rfDataA | input | 32 | Register file read data A |
| rfDataB | input | 32 | Register file read data B |
| rfWe | output | 1 | Register write enable |
| rfWaddr | output | 5 | Register write address |
| rfWdata | output | 32 | Register write data |
| aluOp | output | 6 | ALU function code |
| aluStart | output | 1 | ALU start pulse |
| aluResult | input | 32 | ALU result |
| aluDone | input | 1 | Multi-cycle ALU operation complete |
| halted | output | 1 | Processor halted |
| pcOut | output | 20 | Program counter |
| irOut | output | 32 | Instruction register |
| cycleCount | output | 32 | Clock cycle counter |

## Verification
The test program mixes single-cycle and multi-cycle ALU operations, a store followed by a load from the same address, and a load with a negative offset that wraps to address 0. Together these separate operand and field decoding from offset sign extension. A taken equal branch jumps over an instruction whose register write would show in the scoreboard, and an untaken not-equal branch is followed by an absolute jump, so wrong PC selection shows up as an unexpected or missing write. Memory latency varies per access, and the first access takes 100 cycles, which exposes any progress made before done. The program ends in a halt, followed by single steps with run low and a counter clear, which separate halt, idle and counting behaviour.

// File: rtl/fxPkg.sv
package fxPkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_FETCH_REQ, ST_FETCH_WAIT, ST_DECODE,
    ST_EXEC, ST_EXEC_WAIT, ST_MEM_REQ, ST_MEM_WAIT, ST_WRITEBACK, ST_HALT
  } fxState_e;

  typedef enum logic [1:0] {
    FMT_ALU = 2'b00, FMT_MEM = 2'b01, FMT_BR = 2'b10, FMT_JMP = 2'b11
  } fxFmt_e;

  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_BR, PC_JMP} fxPcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    fxPcSel_e pcSel;
    logic     loadIr;
    logic     addrData;
    logic     capAlu;
    logic     capMem;
    logic     rfWe;
    logic     cntRun;
  } fxStrobe_t;

  // decode flags from datapath to control
  typedef struct packed {
    fxFmt_e fmt;
    logic   isStore;
    logic   isMulti;
    logic   isHalt;
  } fxDecode_t;
endpackage

// File: rtl/fxDatapath.sv
module fxDatapath
  import fxPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int OP_W   = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fxStrobe_t         strobe,
  input  logic              cycClr,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] aluResult,
  output fxDecode_t         dec,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [REG_AW-1:0] rfRdA,
  output logic [REG_AW-1:0] rfRdB,
  output logic [REG_AW-1:0] rfWaddr,
  output logic [DATA_W-1:0] rfWdata,
  output logic [OP_W-1:0]   aluOp,
  output logic [CNT_W-1:0]  cycleCount
);
  localparam int OFF_W = 16;
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] HALT_ADDR = {ADDR_W{1'b1}};

  logic [DATA_W-1:0] resReg;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] dataAddr;
  logic [ADDR_W-1:0] jmpTarget;
  logic              brTaken;
  logic              brNe;

  assign offExt    = {{EXT_W{ir[OFF_W-1]}}, ir[OFF_W-1:0]};
  assign jmpTarget = ir[ADDR_W-1:0];
  assign dataAddr  = rfDataA[ADDR_W-1:0] + offExt;
  assign brNe      = ir[29];
  assign brTaken   = brNe ? (rfDataA != rfDataB) : (rfDataA == rfDataB);

  assign dec.fmt     = fxFmt_e'(ir[31:30]);
  assign dec.isStore = ir[29];
  assign dec.isMulti = ir[5];
  assign dec.isHalt  = (jmpTarget == HALT_ADDR);

  // register selects per format
  always_comb begin
    if (dec.fmt == FMT_ALU) begin
      rfRdA   = ir[24:20];
      rfRdB   = ir[19:15];
      rfWaddr = ir[29:25];
    end else begin
      rfRdA   = ir[23:19];
      rfRdB   = ir[28:24];
      rfWaddr = ir[28:24];
    end
  end

  assign aluOp    = ir[OP_W-1:0];
  assign memAddr  = strobe.addrData ? dataAddr : pc;
  assign memWdata = rfDataB;
  assign rfWdata  = resReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      ir     <= '0;
      resReg <= '0;
    end else begin
      if (strobe.loadIr) ir <= memRdata;
      if (strobe.capAlu) resReg <= aluResult;
      else if (strobe.capMem) resReg <= memRdata;
      case (strobe.pcSel)
        PC_INC:  pc <= pc + 1'b1;
        PC_BR:   pc <= brTaken ? pc + offExt : pc + 1'b1;
        PC_JMP:  pc <= jmpTarget;
        default: pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cycClr) cycleCount <= '0;
    else if (strobe.cntRun) cycleCount <= cycleCount + 1'b1;
  end
endmodule

// File: rtl/fxControl.sv
module fxControl
  import fxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      stepReq,
  input  logic      memDone,
  input  logic      aluDone,
  input  fxDecode_t dec,
  output fxStrobe_t strobe,
  output logic      memReq,
  output logic      memWe,
  output logic      aluStart,
  output logic      halted
);
  fxState_e state, nxt, endNext;
  logic     stepLatch;

  assign endNext = (runEn && !stepLatch) ? ST_FETCH_REQ : ST_IDLE;
  assign halted  = (state == ST_HALT);

  always_comb begin
    nxt             = state;
    strobe          = '0;
    strobe.pcSel    = PC_HOLD;
    strobe.cntRun   = (state != ST_HALT);
    memReq          = 1'b0;
    memWe           = 1'b0;
    aluStart        = 1'b0;
    case (state)
      ST_RESET:      nxt = ST_IDLE;
      ST_IDLE:       if (runEn || stepReq) nxt = ST_FETCH_REQ;
      ST_FETCH_REQ: begin
        memReq = 1'b1;
        nxt    = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: if (memDone) begin
        strobe.loadIr = 1'b1;
        nxt           = ST_DECODE;
      end
      ST_DECODE: begin
        case (dec.fmt)
          FMT_JMP: begin
            if (dec.isHalt) begin
              strobe.pcSel = PC_INC;
              nxt          = ST_HALT;
            end else begin
              strobe.pcSel = PC_JMP;
              nxt          = endNext;
            end
          end
          FMT_BR: begin
            strobe.pcSel = PC_BR;
            nxt          = endNext;
          end
          FMT_ALU: nxt = ST_EXEC;
          default: nxt = ST_MEM_REQ;
        endcase
      end
      ST_EXEC: begin
        aluStart = 1'b1;
        if (dec.isMulti) nxt = ST_EXEC_WAIT;
        else begin
          strobe.capAlu = 1'b1;
          nxt           = ST_WRITEBACK;
        end
      end
      ST_EXEC_WAIT: if (aluDone) begin
        strobe.capAlu = 1'b1;
        nxt           = ST_WRITEBACK;
      end
      ST_MEM_REQ: begin
        memReq          = 1'b1;
        memWe           = dec.isStore;
        strobe.addrData = 1'b1;
        nxt             = ST_MEM_WAIT;
      end
      ST_MEM_WAIT: begin
        strobe.addrData = 1'b1;
        if (memDone) begin
          if (dec.isStore) begin
            strobe.pcSel = PC_INC;
            nxt          = endNext;
          end else begin
            strobe.capMem = 1'b1;
            nxt           = ST_WRITEBACK;
          end
        end
      end
      ST_WRITEBACK: begin
        strobe.rfWe  = 1'b1;
        strobe.pcSel = PC_INC;
        nxt          = endNext;
      end
      ST_HALT:  if (stepReq) nxt = ST_FETCH_REQ;
      default:  nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_RESET;
      stepLatch <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE) begin
        if (runEn) stepLatch <= 1'b0;
        else if (stepReq) stepLatch <= 1'b1;
      end else if (state == ST_HALT && stepReq) begin
        stepLatch <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fxCtrlTop.sv
module fxCtrlTop
  import fxPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int OP_W   = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              stepReq,
  input  logic              cycClr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone,
  output logic [REG_AW-1:0] rfRdA,
  output logic [REG_AW-1:0] rfRdB,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  output logic              rfWe,
  output logic [REG_AW-1:0] rfWaddr,
  output logic [DATA_W-1:0] rfWdata,
  output logic [OP_W-1:0]   aluOp,
  output logic              aluStart,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluDone,
  output logic              halted,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] irOut,
  output logic [CNT_W-1:0]  cycleCount
);
  fxStrobe_t strobe;
  fxDecode_t dec;

  fxControl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .stepReq(stepReq),
    .memDone(memDone), .aluDone(aluDone), .dec(dec), .strobe(strobe),
    .memReq(memReq), .memWe(memWe), .aluStart(aluStart), .halted(halted)
  );

  fxDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .OP_W(OP_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cycClr(cycClr),
    .memRdata(memRdata), .rfDataA(rfDataA), .rfDataB(rfDataB),
    .aluResult(aluResult), .dec(dec), .pc(pcOut), .ir(irOut),
    .memAddr(memAddr), .memWdata(memWdata), .rfRdA(rfRdA), .rfRdB(rfRdB),
    .rfWaddr(rfWaddr), .rfWdata(rfWdata), .aluOp(aluOp), .cycleCount(cycleCount)
  );

  assign rfWe = strobe.rfWe;
endmodule

// File: rtl/fxCtrlChk.sv
module fxCtrlChk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stepReq,
  input logic              cycClr,
  input logic              memReq,
  input logic              memDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rfWe,
  input logic              aluStart,
  input logic              halted,
  input logic [CNT_W-1:0]  cycleCount
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || (!memDone && $past(memReq))) |=> (memDone || $stable(memAddr))); // R3
  AST_ALU_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    aluStart |=> !aluStart); // R5
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |=> !rfWe); // R6
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memReq && !rfWe)); // R11
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !stepReq) |=> halted); // R11
  AST_CNT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !cycClr) |=> (cycleCount == $past(cycleCount) + 1'b1)); // R12
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !cycClr) |=> $stable(cycleCount)); // R12
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cycClr |=> (cycleCount == '0)); // R12
endmodule

bind fxCtrlTop fxCtrlChk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stepReq(stepReq), .cycClr(cycClr),
  .memReq(memReq), .memDone(memDone), .memAddr(memAddr), .rfWe(rfWe),
  .aluStart(aluStart), .halted(halted), .cycleCount(cycleCount)
);

// File: tb/sim_fxCtrlTop.sv
module sim_fxCtrlTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0, stepReq = 1'b0, cycClr = 1'b0;
  logic memReq, memWe, memDone;
  logic [19:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic [4:0]  rfRdA, rfRdB, rfWaddr;
  logic [31:0] rfDataA, rfDataB, rfWdata, aluResult;
  logic        rfWe, aluStart, aluDone, halted;
  logic [5:0]  aluOp;
  logic [19:0] pcOut;
  logic [31:0] irOut, cycleCount;

  always #5 clk = ~clk;

  fxCtrlTop u0 (.*);

  int nChecks = 0, nFails = 0;
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // instruction encoders
  function automatic logic [31:0] encAlu(int rd, int rs1, int rs2, int fn);
    return {2'b00, 5'(rd), 5'(rs1), 5'(rs2), 9'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] encMem(bit st, int r, int base, int off);
    return {2'b01, st, 5'(r), 5'(base), 3'd0, 16'(off)};
  endfunction
  function automatic logic [31:0] encBr(bit ne, int rs1, int rs2, int off);
    return {2'b10, ne, 5'(rs1), 5'(rs2), 3'd0, 16'(off)};
  endfunction
  function automatic logic [31:0] encJmp(int t);
    return {2'b11, 10'd0, 20'(t)};
  endfunction

  function automatic logic [31:0] progWord(int i);
    case (i)
      0:  return encAlu(3, 1, 2, 0);
      1:  return encAlu(4, 1, 2, 1);
      2:  return encAlu(6, 1, 2, 32);
      3:  return encMem(1, 3, 5, 2);
      4:  return encMem(0, 7, 5, 2);
      5:  return encBr(0, 3, 7, 2);
      6:  return encAlu(8, 1, 1, 0);
      7:  return encBr(1, 3, 7, 5);
      8:  return encJmp(12);
      9, 10, 11: return encAlu(13, 2, 2, 0);
      12: return encAlu(9, 1, 2, 4);
      13: return encMem(0, 10, 5, -40);
      14: return encJmp(20'hFFFFF);
      15: return encAlu(11, 2, 2, 0);
      16: return encAlu(12, 1, 2, 0);
      default: return 32'h0;
    endcase
  endfunction

  // memory model with variable latency
  logic [31:0] mem [0:63];
  int reqNum = 0, lat = 0, busy = 0, extraReq = 0, reqTotal = 0;
  logic [5:0] pendAddr;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= progWord(i);
      memDone <= 1'b0; memRdata <= '0; busy <= 0; reqNum <= 0;
    end else begin
      memDone <= 1'b0;
      if (memReq) begin
        if (busy != 0) extraReq <= extraReq + 1;
        busy     <= 1;
        pendAddr <= memAddr[5:0];
        lat      <= (reqNum == 0) ? 99 : (reqNum * 5) % 7;
        reqNum   <= reqNum + 1;
        if (memWe) mem[memAddr[5:0]] <= memWdata;
      end else if (busy != 0) begin
        if (lat == 0) begin
          memDone  <= 1'b1;
          memRdata <= mem[pendAddr];
          busy     <= 0;
        end else lat <= lat - 1;
      end
    end
  end

  // register file model
  logic [31:0] regs [0:31];
  assign rfDataA = regs[rfRdA];
  assign rfDataB = regs[rfRdB];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
      regs[1] <= 32'd10; regs[2] <= 32'd3; regs[5] <= 32'd40;
    end else if (rfWe) regs[rfWaddr] <= rfWdata;
  end

  // ALU model
  int aluCnt = 0;
  always_comb begin
    case (aluOp)
      6'd0:  aluResult = rfDataA + rfDataB;
      6'd1:  aluResult = rfDataA - rfDataB;
      6'd2:  aluResult = rfDataA & rfDataB;
      6'd4:  aluResult = rfDataA ^ rfDataB;
      6'd32: aluResult = rfDataA * rfDataB;
      default: aluResult = 32'd0;
    endcase
  end
  always @(posedge clk) begin
    if (!rstN) begin aluCnt <= 0; aluDone <= 1'b0; end
    else begin
      aluDone <= 1'b0;
      if (aluStart && aluOp[5]) aluCnt <= 4;
      else if (aluCnt != 0) begin
        aluCnt <= aluCnt - 1;
        if (aluCnt == 1) aluDone <= 1'b1;
      end
    end
  end

  // scoreboard
  typedef struct {
    bit          isMem;
    logic [19:0] addr;
    logic [31:0] data;
    string       tag;
  } expItem_t;
  expItem_t sbq[$];

  task automatic pushRf(int a, logic [31:0] d, string tag);
    expItem_t it;
    it.isMem = 0; it.addr = 20'(a); it.data = d; it.tag = tag;
    sbq.push_back(it);
  endtask
  task automatic pushMem(int a, logic [31:0] d, string tag);
    expItem_t it;
    it.isMem = 1; it.addr = 20'(a); it.data = d; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic compareEvent(bit isMem, logic [19:0] a, logic [31:0] d);
    expItem_t it;
    if (sbq.size() == 0) begin
      check("R8 unexpected write", {isMem, 11'd0, a, d}, 64'd0);
    end else begin
      it = sbq.pop_front();
      check({it.tag, " kind/addr/data"}, {isMem, 11'd0, a, d},
            {it.isMem, 11'd0, it.addr, it.data});
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (memReq) reqTotal++;
      if (rfWe) compareEvent(0, 20'(rfWaddr), rfWdata);
      if (memReq && memWe) compareEvent(1, memAddr, memWdata);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int snap;
    logic [31:0] cnt0;
    pushRf(3, 32'd13, "R5 single add");
    pushRf(4, 32'd7, "R5 single sub");
    pushRf(6, 32'd30, "R5 multi mul");
    pushMem(42, 32'd13, "R7 store");
    pushRf(7, 32'd13, "R6 load");
    pushRf(9, 32'd9, "R9 R10 branch/jump path xor");
    pushRf(10, encAlu(3, 1, 2, 0), "R6 negative offset load");

    repeat (3) @(negedge clk);
    check("R1 pc at reset", pcOut, 0);
    check("R1 halted at reset", halted, 0);
    check("R1 no request at reset", {memReq, rfWe, aluStart}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pc after reset", pcOut, 0);
    check("R1 no request after reset", {memReq, rfWe, aluStart}, 0);

    runEn = 1'b1;
    repeat (50) @(negedge clk);
    check("R3 pc held during slow fetch", pcOut, 0);
    check("R3 one request during slow fetch", reqTotal, 1);
    while (!halted) @(negedge clk);
    runEn = 1'b0;
    check("R11 pc after halt", pcOut, 15);
    check("R2 halt word in IR", irOut, encJmp(20'hFFFFF));
    check("R4 R9 all expected writes seen", sbq.size(), 0);
    check("R3 no request while busy", extraReq, 0);

    snap = reqTotal;
    cnt0 = cycleCount;
    repeat (20) @(negedge clk);
    check("R11 no request while halted", reqTotal, snap);
    check("R11 still halted", halted, 1);
    check("R12 count frozen while halted", cycleCount, cnt0);

    pushRf(11, 32'd6, "R13 step from halt");
    stepReq = 1'b1; @(negedge clk); stepReq = 1'b0;
    repeat (100) @(negedge clk);
    check("R13 pc after step from halt", pcOut, 16);
    check("R13 left halt", halted, 0);
    snap = reqTotal;
    repeat (30) @(negedge clk);
    check("R13 idle after step", reqTotal, snap);

    pushRf(12, 32'd13, "R13 step from idle");
    stepReq = 1'b1; @(negedge clk); stepReq = 1'b0;
    repeat (100) @(negedge clk);
    check("R13 R8 pc after idle step", pcOut, 17);
    check("R13 scoreboard drained", sbq.size(), 0);

    cycClr = 1'b1; @(negedge clk); cycClr = 1'b0;
    check("R12 cleared", cycleCount, 0);
    @(negedge clk);
    check("R12 counts after clear", cycleCount, 1);
    repeat (5) @(negedge clk);
    check("R12 counts while idle", cycleCount, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule